// File: doc/BRIEF.md
# Bitstream Run and Repetition Health Monitor

This block watches a serial random bitstream and the 32-bit words built from it, and raises sticky failure flags when the source looks broken. Two run-length detectors sit on the bit stream. The shorter threshold (34 equal bits by default) marks a long-run failure. The longer threshold (48 equal bits) marks a noise failure. A third detector compares each accepted output word with the word accepted just before it and flags a stuck output when they match.

The flags sit at fixed positions in an 8-bit status vector so that a register interface can map it straight onto a status/acknowledge register. Each flag stays set until a one is pulsed on the matching bit of the clear input. An enable input lets the owner park the detectors: while it is low, the run tracker returns to its idle state and the word tracker forgets its previous word. The flags keep their value while the block is disabled.

Two small state machines carry the behaviour. The run tracker has the states `RT_IDLE` (no previous bit) and `RT_COUNT` (counting a run). Its transitions are: first valid bit, IDLE to COUNT; disable, COUNT to IDLE; and any valid bit while in COUNT, which stays in COUNT and either extends the run or restarts it. The word tracker has the states `WR_EMPTY` (no previous word) and `WR_PRIMED` (previous word held). Its transitions are: first valid word, EMPTY to PRIMED; disable, PRIMED to EMPTY; and any valid word while PRIMED, which stays in PRIMED, compares the word and stores it.

Top module: `health_monitor`

## Requirements
- R1: When the LONG_THR-th consecutive equal valid bit is accepted (default 34), status bit 5 is set at that clock edge. A run of LONG_THR-1 equal bits leaves it clear.
- R2: A valid bit that differs from the previous valid bit restarts the run at length one. Cycles with `bit_vld_i` low neither extend nor break a run.
- R3: The run length saturates at NOISE_THR and does not wrap. One continuous run sets each run flag at most once, so a flag cleared during a run that is still going stays clear.
- R4: When the NOISE_THR-th consecutive equal valid bit is accepted (default 48), status bit 3 is set at that clock edge. A run of NOISE_THR-1 equal bits leaves it clear.
- R5: An accepted word equal to the previous accepted word sets status bit 2. A differing word does not. The first word accepted after reset or after re-enable is never compared.
- R6: Each flag stays set until a one is pulsed on the same bit of `flag_clr_i`. Clear bits at other positions do not affect it.
- R7: If a flag's set condition and its clear pulse occur in the same cycle, the flag ends up set.
- R8: While `enable_i` is low, bit and word inputs are ignored. The run and the previous word are discarded, and the flags hold their values.
- R9: Status bits 7, 6, 4, 1 and 0 always read zero, whatever is written to `flag_clr_i`.
- R10: After reset all status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Detector enable; low parks both trackers |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | Serial random bit |
| word_vld_i | input | 1 | Qualifies `word_i` |
| word_i | input | WORD_W | Output word to test for repetition |
| flag_clr_i | input | 8 | Per-position clear pulses for the status flags |
| flags_o | output | 8 | Sticky status: bit 5 long run, bit 3 noise, bit 2 stuck word |

## Verification
The assertions take the inputs to be known, two-state values at every clock edge after reset, and they read a valid qualifier together with its data in the same cycle. They also rely on NOISE_THR being larger than LONG_THR, which the default parameters satisfy. The bench changes every input on the falling edge and returns each qualifier and clear pulse to zero one cycle later, so each accepted bit or word is a single-cycle event. It reads `flags_o` only at falling edges.

// File: rtl/hm_pkg.sv
package hm_pkg;
    localparam int STAT_W     = 8;
    localparam int FLAG_LONG  = 5;
    localparam int FLAG_NOISE = 3;
    localparam int FLAG_STUCK = 2;

    localparam logic [STAT_W-1:0] IMPL_MASK =
        (STAT_W'(1) << FLAG_LONG) | (STAT_W'(1) << FLAG_NOISE) | (STAT_W'(1) << FLAG_STUCK);

    typedef enum logic {
        RT_IDLE,
        RT_COUNT
    } rt_state_e;

    typedef enum logic {
        WR_EMPTY,
        WR_PRIMED
    } wr_state_e;
endpackage

// File: rtl/run_tracker.sv
module run_tracker
    import hm_pkg::*;
#(
    parameter int LONG_THR  = 34,
    parameter int NOISE_THR = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic long_hit_o,
    output logic noise_hit_o
);
    localparam int CNT_W = $clog2(NOISE_THR + 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(NOISE_THR);
    localparam logic [CNT_W-1:0] LONG_PRE  = CNT_W'(LONG_THR - 1);
    localparam logic [CNT_W-1:0] NOISE_PRE = CNT_W'(NOISE_THR - 1);

    rt_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_q, last_d;
    logic             same_bit;

    assign same_bit = (bit_i == last_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RT_IDLE;
            cnt_q   <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            last_q  <= last_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        last_d  = last_q;
        if (!enable_i) begin
            state_d = RT_IDLE;
            cnt_d   = '0;
            last_d  = 1'b0;
        end else if (bit_vld_i) begin
            unique case (state_q)
                RT_IDLE: begin
                    state_d = RT_COUNT;
                    cnt_d   = CNT_W'(1);
                    last_d  = bit_i;
                end
                RT_COUNT: begin
                    last_d = bit_i;
                    if (!same_bit)
                        cnt_d = CNT_W'(1);
                    else if (cnt_q != CNT_MAX)
                        cnt_d = cnt_q + CNT_W'(1);
                end
            endcase
        end
    end

    // outputs: pulse on the bit that brings the run to a threshold
    always_comb begin
        long_hit_o  = 1'b0;
        noise_hit_o = 1'b0;
        unique case (state_q)
            RT_IDLE: begin
                long_hit_o  = 1'b0;
                noise_hit_o = 1'b0;
            end
            RT_COUNT: begin
                long_hit_o  = enable_i && bit_vld_i && same_bit && (cnt_q == LONG_PRE);
                noise_hit_o = enable_i && bit_vld_i && same_bit && (cnt_q == NOISE_PRE);
            end
        endcase
    end

    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && bit_vld_i && state_q == RT_COUNT && !same_bit) |=> (cnt_q == CNT_W'(1)));

    a_r2_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !bit_vld_i) |=> $stable(cnt_q));

    a_r3_single_long: assert property (@(posedge clk) disable iff (!rst_n)
        long_hit_o |=> !long_hit_o);

    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_q == RT_IDLE && cnt_q == '0));
endmodule

// File: rtl/word_repeat.sv
module word_repeat
    import hm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              stuck_hit_o
);
    wr_state_e         state_q, state_d;
    logic [WORD_W-1:0] prev_q, prev_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_EMPTY;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= prev_d;
        end
    end

    always_comb begin
        state_d = state_q;
        prev_d  = prev_q;
        if (!enable_i) begin
            state_d = WR_EMPTY;
            prev_d  = '0;
        end else if (word_vld_i) begin
            unique case (state_q)
                WR_EMPTY:  state_d = WR_PRIMED;
                WR_PRIMED: state_d = WR_PRIMED;
            endcase
            prev_d = word_i;
        end
    end

    always_comb begin
        stuck_hit_o = 1'b0;
        unique case (state_q)
            WR_EMPTY:  stuck_hit_o = 1'b0;
            WR_PRIMED: stuck_hit_o = enable_i && word_vld_i && (word_i == prev_q);
        endcase
    end

    a_r5_prime: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && word_vld_i) |=> (state_q == WR_PRIMED && prev_q == $past(word_i)));

    a_r8_word_forget: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_q == WR_EMPTY));
endmodule

// File: rtl/flag_bank.sv
module flag_bank
    import hm_pkg::*;
#(
    parameter logic [STAT_W-1:0] SET_MASK = IMPL_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] flags_o
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        if (SET_MASK[i]) begin : g_live
            logic flag_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else if (set_i[i])
                    flag_q <= 1'b1;
                else if (clr_i[i])
                    flag_q <= 1'b0;
            end
            assign flags_o[i] = flag_q;

            a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_o[i] && !clr_i[i]) |=> flags_o[i]);

            a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !flags_o[i]);

            a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> flags_o[i]);
        end else begin : g_tied
            assign flags_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/health_monitor.sv
module health_monitor
    import hm_pkg::*;
#(
    parameter int LONG_THR  = 34,
    parameter int NOISE_THR = 48,
    parameter int WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [STAT_W-1:0] flag_clr_i,
    output logic [STAT_W-1:0] flags_o
);
    logic              long_hit;
    logic              noise_hit;
    logic              stuck_hit;
    logic [STAT_W-1:0] set_vec;

    run_tracker #(
        .LONG_THR (LONG_THR),
        .NOISE_THR(NOISE_THR)
    ) i_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .bit_vld_i  (bit_vld_i),
        .bit_i      (bit_i),
        .long_hit_o (long_hit),
        .noise_hit_o(noise_hit)
    );

    word_repeat #(
        .WORD_W(WORD_W)
    ) i_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .word_vld_i (word_vld_i),
        .word_i     (word_i),
        .stuck_hit_o(stuck_hit)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[FLAG_LONG]  = long_hit;
        set_vec[FLAG_NOISE] = noise_hit;
        set_vec[FLAG_STUCK] = stuck_hit;
    end

    flag_bank #(
        .SET_MASK(IMPL_MASK)
    ) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (flag_clr_i),
        .flags_o(flags_o)
    );

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && flag_clr_i == '0) |=> $stable(flags_o));

    a_r3_noise_after_long: assert property (@(posedge clk) disable iff (!rst_n)
        noise_hit |-> !long_hit);
endmodule

// File: tb/test_health_monitor.sv
module test_health_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable_i = 1'b0;
    logic              bit_vld_i = 1'b0;
    logic              bit_i = 1'b0;
    logic              word_vld_i = 1'b0;
    logic [WORD_W-1:0] word_i = '0;
    logic [7:0]        flag_clr_i = '0;
    logic [7:0]        flags_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    health_monitor i_health_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .bit_vld_i (bit_vld_i),
        .bit_i     (bit_i),
        .word_vld_i(word_vld_i),
        .word_i    (word_i),
        .flag_clr_i(flag_clr_i),
        .flags_o   (flags_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] exp);
        n_checks++;
        if (flags_o !== exp) begin
            n_fails++;
            $display("FAIL %s: flags actual %h expected %h", req, flags_o, exp);
        end
    endtask

    task automatic send_bits(input logic b, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bit_vld_i = 1'b1;
            bit_i     = b;
        end
        @(negedge clk);
        bit_vld_i = 1'b0;
    endtask

    task automatic send_word(input logic [WORD_W-1:0] w, input logic [7:0] clr);
        @(negedge clk);
        word_vld_i = 1'b1;
        word_i     = w;
        flag_clr_i = clr;
        @(negedge clk);
        word_vld_i = 1'b0;
        flag_clr_i = '0;
    endtask

    task automatic pulse_clr(input logic [7:0] m);
        @(negedge clk);
        flag_clr_i = m;
        @(negedge clk);
        flag_clr_i = '0;
    endtask

    task automatic rearm();
        @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        enable_i = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 reset state", 8'h00);
    endtask

    task automatic t_long_run();
        send_bits(1'b1, 33);
        check("R1 33 equal bits below threshold", 8'h00);
        send_bits(1'b0, 1);
        check("R2 differing bit restarts run", 8'h00);
        send_bits(1'b0, 16);
        repeat (3) @(negedge clk);
        send_bits(1'b0, 16);
        check("R2 idle gap does not break run, 33 zeros", 8'h00);
        send_bits(1'b0, 1);
        check("R1 34th equal bit sets long-run flag", 8'h20);
    endtask

    task automatic t_noise_run();
        send_bits(1'b0, 13);
        check("R4 47 equal bits below noise threshold", 8'h20);
        send_bits(1'b0, 1);
        check("R4 48th equal bit sets noise flag", 8'h28);
        pulse_clr(8'h28);
        check("R6 clear both run flags", 8'h00);
        send_bits(1'b0, 70);
        check("R3 saturated run does not set again", 8'h00);
    endtask

    task automatic t_clear_select();
        send_bits(1'b1, 48);
        check("R1 R4 fresh run of ones sets both", 8'h28);
        pulse_clr(8'h20);
        check("R6 clear of bit 5 leaves bit 3", 8'h08);
        pulse_clr(8'hD3);
        check("R9 clears at unused positions change nothing", 8'h08);
        pulse_clr(8'h08);
        check("R6 clear of bit 3", 8'h00);
    endtask

    task automatic t_words();
        rearm();
        send_word(32'hA5A5_0001, 8'h00);
        check("R5 first word not compared", 8'h00);
        send_word(32'h1234_5678, 8'h00);
        check("R5 differing word", 8'h00);
        send_word(32'h1234_5678, 8'h00);
        check("R5 repeated word sets stuck flag", 8'h04);
        send_word(32'h0BAD_F00D, 8'h00);
        send_word(32'h0BAD_F00D, 8'h04);
        check("R7 set beats clear in same cycle", 8'h04);
        pulse_clr(8'h04);
        check("R6 clear of stuck flag", 8'h00);
    endtask

    task automatic t_disable();
        rearm();
        send_bits(1'b0, 40);
        check("R1 long flag before disable", 8'h20);
        @(negedge clk);
        enable_i = 1'b0;
        send_bits(1'b1, 60);
        send_word(32'hCAFE_0000, 8'h00);
        send_word(32'hCAFE_0000, 8'h00);
        check("R8 inputs ignored and flags held while disabled", 8'h20);
        @(negedge clk);
        enable_i = 1'b1;
        send_bits(1'b0, 10);
        check("R8 run discarded on disable", 8'h20);
        send_word(32'h1234_5678, 8'h00);
        check("R8 previous word discarded on disable", 8'h20);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clears flags", 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
        enable_i = 1'b1;
        t_reset();
        t_long_run();
        t_noise_run();
        t_clear_select();
        t_words();
        t_disable();
        t_reset_again();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule